// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits next to a small 8-bit CPU core and takes six interrupt sources: two external request lines, the flags of timers 0 and 1, the two flags of timer 2 (overflow and external) and the two flags of the serial port (receive and transmit). Each source can be masked on its own, and a global enable masks all of them. Each source carries a two-bit priority level built from one bit in a "level high" register and one bit in a "level low" register. That gives four levels, with 3 the most urgent.

On each cycle the controller picks the most urgent eligible source. It checks that source against the levels currently in service. It then offers the CPU a request strobe together with a three-bit vector index. The offer stays frozen until the CPU acknowledges it. The acknowledge marks the offered level as in service. A return-from-interrupt pulse retires the most urgent level in service. With these two events, handlers nest: a handler can be interrupted only by a source at a strictly more urgent level.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset all enable and level registers read as zero and no level is in service, so `irqReq` stays low even while every request line is high.
- R2: Source vectors are ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5. The serial source is pending when either bit of `serFlags` is high. Timer 2 is pending when either bit of `tmr2Flags` is high. `extReq[0]`/`extReq[1]` are ext0/ext1 and `tmrReq[0]`/`tmrReq[1]` are timer0/timer1.
- R3: Writing `regSel`=0 loads the enable register. Bit i (0..5) enables the source with vector i, and bit 6 is the global enable. A source is eligible only when its own bit and bit 6 are both 1.
- R4: The level of the source with vector i is {high bit i, low bit i}. `regSel`=1 loads the low bits and `regSel`=2 loads the high bits. Among eligible sources, the one at the numerically highest level is offered.
- R5: Among eligible sources at the same highest level, the one with the smallest vector index is offered. This gives the polling order ext0, timer0, ext1, timer1, serial, timer2.
- R6: An eligible request seen in cycle n raises `irqReq` after the edge that ends cycle n. While `irqReq` is high without `cpuAck`, `irqVec` does not change, even if more urgent sources arrive. `irqReq` falls after the edge at which `cpuAck` is seen.
- R7: `cpuAck` while `irqReq` is high marks the offered level as in service. A new offer is made only for a level strictly above every level in service. While level 3 is in service, nothing is offered.
- R8: `cpuReti` retires only the most urgent level in service. Less urgent levels stay in service and keep blocking requests at or below their own level.
- R9: A register write made at an edge governs arbitration from the cycle that follows it. As a result, `irqReq` can rise no earlier than the second edge after the write is driven. A write does not alter an offer that is already being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 enable, 1 level low, 2 level high |
| regWrData | input | 7 | Write data |
| extReq | input | 2 | External requests: bit 0 ext0, bit 1 ext1 |
| tmrReq | input | 2 | Timer flags: bit 0 timer0, bit 1 timer1 |
| tmr2Flags | input | 2 | Timer 2 overflow and external flags |
| serFlags | input | 2 | Serial receive and transmit flags |
| cpuAck | input | 1 | CPU takes the offered request |
| cpuReti | input | 1 | Return from the current handler |
| irqReq | output | 1 | Request strobe to the CPU |
| irqVec | output | 3 | Vector index of the offered source |

## Verification
The in-service mask can only be seen through its effect on which requests get offered. A bit that is wrongly set would silence a legal preemption. A bit that is wrongly cleared would let an equal-level source in. Either error shows up at `irqReq` one edge after the next offer should or should not have been made. For that reason the nesting sequence probes each level boundary right after every acknowledge and every return. A wrong tie-break, bit pairing or flag merge shows up as a wrong `irqVec` on the first offer of a single random trial.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int VEC_W   = $clog2(NUM_SRC);
  localparam int REG_W   = NUM_SRC + 1;
  localparam int GLB_BIT = REG_W - 1;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_LVL_LO = 2'd1,
    SEL_LVL_HI = 2'd2
  } regSel_e;

  typedef struct packed {
    logic latchReq;
    logic commitLvl;
    logic retireLvl;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  ctlStrobe_t         strobe,
  output logic               candValid,
  output logic [VEC_W-1:0]   heldVec,
  output logic [NUM_LVL-1:0] inService
);
  logic [REG_W-1:0]   enReg;
  logic [NUM_SRC-1:0] loReg;
  logic [NUM_SRC-1:0] hiReg;
  logic [NUM_SRC-1:0] eligible;
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic               bestFound;
  logic [LVL_W-1:0]   bestLvl;
  logic [VEC_W-1:0]   bestIdx;
  logic               isAny;
  logic [LVL_W-1:0]   topLvl;
  logic [LVL_W-1:0]   heldLvl;
  logic [NUM_LVL-1:0] isNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
      loReg <= '0;
      hiReg <= '0;
    end else if (regWrEn) begin
      case (regSel)
        SEL_ENABLE: enReg <= regWrData;
        SEL_LVL_LO: loReg <= regWrData[NUM_SRC-1:0];
        SEL_LVL_HI: hiReg <= regWrData[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    assign srcLvl[i]   = {hiReg[i], loReg[i]};
    assign eligible[i] = srcRaw[i] & enReg[i] & enReg[GLB_BIT];
  end

  // Scan from last to first so that equal levels end on the lowest index.
  always_comb begin
    bestFound = 1'b0;
    bestLvl   = '0;
    bestIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!bestFound || srcLvl[i] >= bestLvl)) begin
        bestFound = 1'b1;
        bestLvl   = srcLvl[i];
        bestIdx   = VEC_W'(i);
      end
    end
  end

  always_comb begin
    isAny  = |inService;
    topLvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (inService[l]) topLvl = LVL_W'(l);
    end
  end

  assign candValid = bestFound && (!isAny || bestLvl > topLvl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVec <= '0;
      heldLvl <= '0;
    end else if (strobe.latchReq) begin
      heldVec <= bestIdx;
      heldLvl <= bestLvl;
    end
  end

  always_comb begin
    isNext = inService;
    if (strobe.retireLvl && isAny) isNext[topLvl] = 1'b0;
    if (strobe.commitLvl) isNext[heldLvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) inService <= '0;
    else       inService <= isNext;
  end
endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       candValid,
  input  logic       cpuAck,
  input  logic       cpuReti,
  output ctlStrobe_t strobe,
  output logic       irqReq
);
  typedef enum logic {ST_IDLE, ST_OFFER} state_e;
  state_e state, stateNext;

  always_comb begin
    strobe           = '0;
    strobe.latchReq  = (state == ST_IDLE) && candValid;
    strobe.commitLvl = (state == ST_OFFER) && cpuAck;
    strobe.retireLvl = cpuReti;
    stateNext        = state;
    if (strobe.latchReq)  stateNext = ST_OFFER;
    if (strobe.commitLvl) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign irqReq = (state == ST_OFFER);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic [1:0]       extReq,
  input  logic [1:0]       tmrReq,
  input  logic [1:0]       tmr2Flags,
  input  logic [1:0]       serFlags,
  input  logic             cpuAck,
  input  logic             cpuReti,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVec
);
  logic [NUM_SRC-1:0] srcRaw;
  logic [NUM_LVL-1:0] inService;
  logic               candValid;
  ctlStrobe_t         strobe;

  // Index equals vector number, which is also the polling order.
  assign srcRaw = {|tmr2Flags, |serFlags, tmrReq[1], extReq[1], tmrReq[0], extReq[0]};

  irq_nest_dp uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .srcRaw(srcRaw), .strobe(strobe),
    .candValid(candValid), .heldVec(irqVec), .inService(inService)
  );

  irq_nest_ctl uCtl (
    .clk(clk), .rstN(rstN), .candValid(candValid), .cpuAck(cpuAck),
    .cpuReti(cpuReti), .strobe(strobe), .irqReq(irqReq)
  );
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cpuAck,
  input logic               cpuReti,
  input logic               irqReq,
  input logic [VEC_W-1:0]   irqVec,
  input logic [NUM_LVL-1:0] inService
);
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !cpuAck |=> irqReq && $stable(irqVec)); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && cpuAck |=> !irqReq); // R6

  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    inService[NUM_LVL-1] && !irqReq && !cpuReti |=> !irqReq); // R7

  AST_ACK_ADDS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && cpuAck && !cpuReti |=>
      $countones(inService) == $countones($past(inService)) + 1); // R7

  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReti && !(irqReq && cpuAck) && (inService != '0) |=>
      $countones(inService) == $countones($past(inService)) - 1); // R8
endmodule

bind irq_nest_ctrl irq_nest_chk uChk (
  .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .cpuReti(cpuReti),
  .irqReq(irqReq), .irqVec(irqVec), .inService(inService)
);

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [1:0] regSel;
  logic [6:0] regWrData;
  logic [1:0] extReq, tmrReq, tmr2Flags, serFlags;
  logic       cpuAck, cpuReti;
  logic       irqReq;
  logic [2:0] irqVec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irq_nest_ctrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .extReq(extReq), .tmrReq(tmrReq),
    .tmr2Flags(tmr2Flags), .serFlags(serFlags), .cpuAck(cpuAck),
    .cpuReti(cpuReti), .irqReq(irqReq), .irqVec(irqVec)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [6:0] d);
    regWrEn = 1'b1; regSel = s; regWrData = d;
    tick;
    regWrEn = 1'b0;
  endtask

  task automatic setSrc(input logic [5:0] v, input bit alt);
    extReq    = {v[2], v[0]};
    tmrReq    = {v[3], v[1]};
    tmr2Flags = alt ? {v[5], 1'b0} : {1'b0, v[5]};
    serFlags  = alt ? {1'b0, v[4]} : {v[4], 1'b0};
  endtask

  task automatic serve;
    cpuAck = 1'b1;
    tick;
    cpuAck = 1'b0;
  endtask

  task automatic retn;
    cpuReti = 1'b1;
    tick;
    cpuReti = 1'b0;
  endtask

  // exp = {request expected, vector}
  task automatic expectOut(input string tag, input logic [3:0] exp);
    checks++;
    if (irqReq !== exp[3] || (exp[3] && irqVec !== exp[2:0])) begin
      errors++;
      $display("FAIL %s: actual req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irqReq, irqVec, exp[3], exp[2:0]);
    end
  endtask

  function automatic logic [3:0] bestOf(input logic [5:0] req, input logic [6:0] en,
                                        input logic [5:0] lo, input logic [5:0] hi);
    int bl = -1;
    int bi = 0;
    for (int i = 0; i < 6; i++) begin
      if (req[i] && en[i] && en[6]) begin
        int lv = int'({hi[i], lo[i]});
        if (lv > bl) begin bl = lv; bi = i; end
      end
    end
    return (bl >= 0) ? {1'b1, 3'(bi)} : 4'b0;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; regWrEn = 1'b0; regSel = '0; regWrData = '0;
    cpuAck = 1'b0; cpuReti = 1'b0;
    setSrc(6'h3F, 1'b0);
    repeat (3) tick;
    rstN = 1'b1;
    tick; tick;
    expectOut("R1 reset leaves requests masked", 4'b0000);
    setSrc(6'h00, 1'b0);

    // R2 source mapping, both flags of merged sources
    wr(2'd0, 7'h7F); wr(2'd1, 7'h00); wr(2'd2, 7'h00);
    for (int i = 0; i < 6; i++) begin
      for (int a = 0; a < 2; a++) begin
        setSrc(6'(1 << i), a[0]);
        tick;
        expectOut("R2 single source vector", {1'b1, 3'(i)});
        setSrc(6'h00, 1'b0); serve; retn;
      end
    end

    // R3 global and individual enables
    wr(2'd0, 7'h3F);
    setSrc(6'h3F, 1'b0); tick;
    expectOut("R3 global bit clear masks all", 4'b0000);
    wr(2'd0, 7'h44); tick;
    expectOut("R3 only ext1 enabled", {1'b1, 3'd2});
    setSrc(6'h00, 1'b0); serve; retn;

    // R4 level from {high, low}
    wr(2'd0, 7'h7F); wr(2'd1, 7'h01); wr(2'd2, 7'h08);
    setSrc(6'h09, 1'b0); tick;
    expectOut("R4 timer1 level2 over ext0 level1", {1'b1, 3'd3});
    setSrc(6'h00, 1'b0); serve; retn;
    wr(2'd1, 7'h21); wr(2'd2, 7'h28);
    setSrc(6'h29, 1'b0); tick;
    expectOut("R4 timer2 level3 wins", {1'b1, 3'd5});
    setSrc(6'h00, 1'b0); serve; retn;

    // R5 polling order at equal level
    wr(2'd1, 7'h00); wr(2'd2, 7'h3F);
    for (int k = 0; k < 6; k++) begin
      setSrc(6'h3F << k, 1'b1); tick;
      expectOut("R5 polling order tie", {1'b1, 3'(k)});
      setSrc(6'h00, 1'b0); serve; retn;
    end

    // R6/R9: offer frozen; late writes and urgent arrivals ignored
    wr(2'd1, 7'h1B); wr(2'd2, 7'h1C);   // levels: 1,1,2,3,3,0
    setSrc(6'h20, 1'b0); tick;
    expectOut("R6 timer2 offered", {1'b1, 3'd5});
    setSrc(6'h30, 1'b0); tick;
    expectOut("R6 vector held against urgent arrival", {1'b1, 3'd5});
    wr(2'd0, 7'h00);
    expectOut("R9 enable write leaves offer intact", {1'b1, 3'd5});
    setSrc(6'h00, 1'b0); serve;
    expectOut("R6 ack drops request", 4'b0000);
    retn;
    setSrc(6'h08, 1'b0); tick;
    expectOut("R3 disabled source not offered", 4'b0000);
    wr(2'd0, 7'h7F);
    expectOut("R9 no offer in write cycle", 4'b0000);
    tick;
    expectOut("R9 offer one cycle after write", {1'b1, 3'd3});
    setSrc(6'h00, 1'b0); serve; retn;

    // R7/R8 nesting
    setSrc(6'h01, 1'b0); tick;
    expectOut("R7 ext0 level1 offered", {1'b1, 3'd0});
    setSrc(6'h00, 1'b0); serve;                  // IS {1}
    setSrc(6'h02, 1'b0); tick;
    expectOut("R7 equal level waits", 4'b0000);
    tick;
    expectOut("R7 equal level still waits", 4'b0000);
    setSrc(6'h06, 1'b0); tick;
    expectOut("R7 level2 preempts", {1'b1, 3'd2});
    setSrc(6'h02, 1'b0); serve;                  // IS {1,2}
    tick;
    expectOut("R7 level1 blocked under level2", 4'b0000);
    setSrc(6'h0A, 1'b0); tick;
    expectOut("R7 level3 preempts", {1'b1, 3'd3});
    setSrc(6'h02, 1'b0); serve;                  // IS {1,2,3}
    setSrc(6'h12, 1'b0); tick;
    expectOut("R7 level3 in service blocks level3", 4'b0000);
    tick;
    expectOut("R7 level3 in service still blocks", 4'b0000);
    retn;                                        // IS {1,2}
    expectOut("R8 no offer in return cycle", 4'b0000);
    tick;
    expectOut("R8 serial level3 offered after return", {1'b1, 3'd4});
    setSrc(6'h02, 1'b0); serve;                  // IS {1,2,3}
    retn;                                        // IS {1,2}
    setSrc(6'h06, 1'b0); tick;
    expectOut("R8 level2 still in service", 4'b0000);
    retn;                                        // IS {1}
    tick;
    expectOut("R8 level2 offered after second return", {1'b1, 3'd2});
    setSrc(6'h02, 1'b0); serve;                  // IS {1,2}
    retn; retn;                                  // IS {}
    tick;
    expectOut("R8 level1 offered when all retired", {1'b1, 3'd1});
    setSrc(6'h00, 1'b0); serve; retn;

    // Random arbitration against the bench model
    for (int t = 0; t < 40; t++) begin
      logic [5:0] lo, hi, rq;
      logic [6:0] en;
      logic [3:0] exp;
      lo = 6'($urandom); hi = 6'($urandom); rq = 6'($urandom);
      en = {($urandom % 4) != 0, 6'($urandom)};
      exp = bestOf(rq, en, lo, hi);
      wr(2'd0, en); wr(2'd1, {1'b0, lo}); wr(2'd2, {1'b0, hi});
      setSrc(rq, 1'($urandom)); tick;
      expectOut("R4 R5 random arbitration", exp);
      setSrc(6'h00, 1'b0);
      if (exp[3]) begin serve; retn; end
      else tick;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule